// File: doc/BRIEF.md
# Interrupt Vector Mapper

This block gathers two groups of interrupt sources: a bank of general-purpose user wires and a bank of DMA channel lines. The channel lines are the host-to-card channels followed by the card-to-host channels. Each group has a request register that shows the raw input levels. Each group also has an enable register, which can be written whole, OR-ed through a set alias or cleared through a clear alias. The pending registers show request AND enable.

A source raises an interrupt once, when its pending bit rises. The block then looks up the source's 8-bit vector number in a programmable table and sends that number as a single message on a valid/ready output. Each 32-bit table word holds four vector entries. When several sources wait at once, channel sources go first and lower indices win within a group. Software configures and inspects the block through a simple 32-bit register port. Writes are strobed and reads are combinational.

Top module: `irq_vec_mapper`

## Requirements
- R1: After synchronous reset, msg_valid is 0, both enable registers read 0, both pending registers read 0 and all vector entries read 0.
- R2: The user request register (word 8) and the channel request register (word 9) read the raw input levels, one clock after the inputs change.
- R3: A write to an enable register (user word 1, channel word 4) replaces it. A write to the set alias (words 2 and 5) ORs in the one bits. A write to the clear alias (words 3 and 6) clears the one bits. Bits above the source count read 0.
- R4: The user pending register (word 10) and the channel pending register (word 11) read request AND enable.
- R5: Vector entry k of a group sits in table word k/4, at bits 8*(k%4)+7 down to 8*(k%4). The user table starts at word 16 and the channel table at word 24. Table words read back as written.
- R6: Each rising edge of a source's pending bit produces exactly one message. A level held high produces no further message. A new message needs the pending bit to go low for at least one cycle and rise again.
- R7: A source whose enable bit is 0 produces no message. Setting the enable bit while the request is high creates a rising pending edge, and that edge produces a message.
- R8: When several sources wait, channel sources are issued before user sources, and a lower index wins within a group.
- R9: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and msg_vec does not change.
- R10: Channel bit i is h2c_irq[i] for i below NUM_H2C. Channel bit NUM_H2C+j is c2h_irq[j].
- R11: Word 0 reads the identifier constant ID_VALUE, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| user_irq | input | NUM_USER | User interrupt levels |
| h2c_irq | input | NUM_H2C | Host-to-card channel interrupt levels |
| c2h_irq | input | NUM_C2H | Card-to-host channel interrupt levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| msg_valid | output | 1 | Vector message valid |
| msg_ready | input | 1 | Vector message accepted |
| msg_vec | output | 8 | Vector number of the message |

## Verification
The enable registers are driven through a table of write, set and clear patterns. Overlapping and out-of-range bit masks separate a true OR/AND-NOT from a plain overwrite, and also show whether the upper bits are truncated.

The edge behaviour is tested with one source in several ways: held high while masked, then unmasked while still high, then held high, then dropped and raised again. This distinguishes edge-triggered from level-triggered issue.

Four sources from both groups and both channel directions are raised in the same cycle. The order in which their distinct vectors come out exposes any error in group priority, in index order or in the host-to-card/card-to-host numbering.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int VEC_W  = 8;
    localparam int LANES  = DATA_W / VEC_W;

    localparam logic [ADDR_W-1:0] A_ID      = 6'd0;
    localparam logic [ADDR_W-1:0] A_UEN     = 6'd1;
    localparam logic [ADDR_W-1:0] A_UEN_SET = 6'd2;
    localparam logic [ADDR_W-1:0] A_UEN_CLR = 6'd3;
    localparam logic [ADDR_W-1:0] A_CEN     = 6'd4;
    localparam logic [ADDR_W-1:0] A_CEN_SET = 6'd5;
    localparam logic [ADDR_W-1:0] A_CEN_CLR = 6'd6;
    localparam logic [ADDR_W-1:0] A_UREQ    = 6'd8;
    localparam logic [ADDR_W-1:0] A_CREQ    = 6'd9;
    localparam logic [ADDR_W-1:0] A_UPEND   = 6'd10;
    localparam logic [ADDR_W-1:0] A_CPEND   = 6'd11;
    localparam int                UTBL_BASE = 16;
    localparam int                CTBL_BASE = 24;

    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic [1:0] {
        EN_NONE,
        EN_LOAD,
        EN_SET,
        EN_CLR
    } en_op_e;

    // word address holding entry k of a table starting at base
    function automatic logic [ADDR_W-1:0] tbl_word(input int base, input int k);
        return ADDR_W'(base + k / LANES);
    endfunction

    function automatic int tbl_lsb(input int k);
        return (k % LANES) * VEC_W;
    endfunction
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
    import irq_vec_pkg::*;
#(
    parameter int               NUM_USER = 16,
    parameter int               NUM_CHAN = 8,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h5A17_0100
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [NUM_USER-1:0]      user_req,
    input  logic [NUM_CHAN-1:0]      chan_req,
    output logic [DATA_W-1:0]        rdata,
    output logic [NUM_USER-1:0]      user_en,
    output logic [NUM_CHAN-1:0]      chan_en,
    output logic [NUM_USER-1:0][VEC_W-1:0] user_vec,
    output logic [NUM_CHAN-1:0][VEC_W-1:0] chan_vec
);
    en_op_e uop, cop;

    always_comb begin
        uop = EN_NONE;
        cop = EN_NONE;
        if (we) begin
            case (addr)
                A_UEN:     uop = EN_LOAD;
                A_UEN_SET: uop = EN_SET;
                A_UEN_CLR: uop = EN_CLR;
                A_CEN:     cop = EN_LOAD;
                A_CEN_SET: cop = EN_SET;
                A_CEN_CLR: cop = EN_CLR;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            user_en <= '0;
            chan_en <= '0;
        end else begin
            case (uop)
                EN_LOAD: user_en <= wdata[NUM_USER-1:0];
                EN_SET:  user_en <= user_en | wdata[NUM_USER-1:0];
                EN_CLR:  user_en <= user_en & ~wdata[NUM_USER-1:0];
                default: ;
            endcase
            case (cop)
                EN_LOAD: chan_en <= wdata[NUM_CHAN-1:0];
                EN_SET:  chan_en <= chan_en | wdata[NUM_CHAN-1:0];
                EN_CLR:  chan_en <= chan_en & ~wdata[NUM_CHAN-1:0];
                default: ;
            endcase
        end
    end

    for (genvar k = 0; k < NUM_USER; k++) begin : g_uvec
        always_ff @(posedge clk) begin
            if (rst)
                user_vec[k] <= '0;
            else if (we && addr == tbl_word(UTBL_BASE, k))
                user_vec[k] <= wdata[tbl_lsb(k) +: VEC_W];
        end
    end

    for (genvar k = 0; k < NUM_CHAN; k++) begin : g_cvec
        always_ff @(posedge clk) begin
            if (rst)
                chan_vec[k] <= '0;
            else if (we && addr == tbl_word(CTBL_BASE, k))
                chan_vec[k] <= wdata[tbl_lsb(k) +: VEC_W];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_ID:                             rdata = ID_VALUE;
            A_UEN, A_UEN_SET, A_UEN_CLR:      rdata[NUM_USER-1:0] = user_en;
            A_CEN, A_CEN_SET, A_CEN_CLR:      rdata[NUM_CHAN-1:0] = chan_en;
            A_UREQ:                           rdata[NUM_USER-1:0] = user_req;
            A_CREQ:                           rdata[NUM_CHAN-1:0] = chan_req;
            A_UPEND:                          rdata[NUM_USER-1:0] = user_req & user_en;
            A_CPEND:                          rdata[NUM_CHAN-1:0] = chan_req & chan_en;
            default: begin
                for (int k = 0; k < NUM_USER; k++)
                    if (addr == tbl_word(UTBL_BASE, k))
                        rdata[tbl_lsb(k) +: VEC_W] = user_vec[k];
                for (int k = 0; k < NUM_CHAN; k++)
                    if (addr == tbl_word(CTBL_BASE, k))
                        rdata[tbl_lsb(k) +: VEC_W] = chan_vec[k];
            end
        endcase
    end

    AST_UEN_SET_ORS: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_UEN_SET) |=>
        ((user_en & $past(wdata[NUM_USER-1:0])) == $past(wdata[NUM_USER-1:0]))); // R3
    AST_CEN_CLR_ANDS: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_CEN_CLR) |=>
        ((chan_en & $past(wdata[NUM_CHAN-1:0])) == '0)); // R3
endmodule

// File: rtl/irqv_edge.sv
module irqv_edge #(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pend,
    input  logic [N-1:0] grant,
    output logic [N-1:0] queued
);
    logic [N-1:0] pend_prev;
    logic [N-1:0] rise;

    assign rise = pend & ~pend_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_prev <= '0;
            queued    <= '0;
        end else begin
            pend_prev <= pend;
            queued    <= (queued & ~grant) | rise;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_QUEUE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
            $rose(queued[i]) |-> $past(rise[i])); // R6
        AST_GRANT_CONSUMES: assert property (@(posedge clk) disable iff (rst)
            grant[i] |=> (!queued[i] || $past(rise[i]))); // R6
    end
endmodule

// File: rtl/irqv_arb.sv
module irqv_arb
    import irq_vec_pkg::*;
#(
    parameter int N = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          queued,
    input  logic [N-1:0][VEC_W-1:0] vec_tbl,
    input  logic                  out_ready,
    output logic [N-1:0]          grant,
    output logic                  out_valid,
    output vec_t                  out_vec
);
    logic load_ok;
    logic found;
    vec_t sel_vec;

    assign load_ok = !out_valid || out_ready;

    // index 0 has the highest priority
    always_comb begin
        grant   = '0;
        found   = 1'b0;
        sel_vec = '0;
        for (int i = 0; i < N; i++) begin
            if (queued[i] && !found) begin
                found   = 1'b1;
                grant[i] = load_ok;
                sel_vec = vec_tbl[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else if (load_ok) begin
            out_valid <= found;
            if (found)
                out_vec <= sel_vec;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R8
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vec))); // R9
    AST_VALID_FROM_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(|grant)); // R7
endmodule

// File: rtl/irq_vec_mapper.sv
module irq_vec_mapper
    import irq_vec_pkg::*;
#(
    parameter int               NUM_USER = 16,
    parameter int               NUM_H2C  = 4,
    parameter int               NUM_C2H  = 4,
    parameter logic [31:0]      ID_VALUE = 32'h5A17_0100
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_USER-1:0] user_irq,
    input  logic [NUM_H2C-1:0]  h2c_irq,
    input  logic [NUM_C2H-1:0]  c2h_irq,
    input  logic                reg_we,
    input  logic [5:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vec
);
    localparam int NUM_CHAN = NUM_H2C + NUM_C2H;
    localparam int NUM_SRC  = NUM_CHAN + NUM_USER;

    logic [NUM_USER-1:0]             user_req_q, user_en;
    logic [NUM_CHAN-1:0]             chan_req_q, chan_en;
    logic [NUM_USER-1:0][VEC_W-1:0]  user_vec;
    logic [NUM_CHAN-1:0][VEC_W-1:0]  chan_vec;
    logic [NUM_SRC-1:0]              src_pend, src_grant, src_queued;
    logic [NUM_SRC-1:0][VEC_W-1:0]   src_vec;

    // host-to-card channels take the low channel numbers
    always_ff @(posedge clk) begin
        if (rst) begin
            user_req_q <= '0;
            chan_req_q <= '0;
        end else begin
            user_req_q <= user_irq;
            chan_req_q <= {c2h_irq, h2c_irq};
        end
    end

    irqv_regs #(
        .NUM_USER (NUM_USER),
        .NUM_CHAN (NUM_CHAN),
        .ID_VALUE (ID_VALUE)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .user_req (user_req_q),
        .chan_req (chan_req_q),
        .rdata    (reg_rdata),
        .user_en  (user_en),
        .chan_en  (chan_en),
        .user_vec (user_vec),
        .chan_vec (chan_vec)
    );

    // channel sources occupy the low (higher priority) source indices
    assign src_pend = {user_req_q & user_en, chan_req_q & chan_en};
    assign src_vec  = {user_vec, chan_vec};

    irqv_edge #(.N(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pend   (src_pend),
        .grant  (src_grant),
        .queued (src_queued)
    );

    irqv_arb #(.N(NUM_SRC)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .queued    (src_queued),
        .vec_tbl   (src_vec),
        .out_ready (msg_ready),
        .grant     (src_grant),
        .out_valid (msg_valid),
        .out_vec   (msg_vec)
    );
endmodule

// File: tb/irq_vec_mapper_test.sv
module irq_vec_mapper_test;
    localparam logic [31:0] ID = 32'h5A17_0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] user_irq = '0;
    logic [3:0]  h2c_irq = '0;
    logic [3:0]  c2h_irq = '0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_vec;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    irq_vec_mapper #(.ID_VALUE(ID)) uut (
        .clk(clk), .rst(rst), .user_irq(user_irq), .h2c_irq(h2c_irq),
        .c2h_irq(c2h_irq), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vec(msg_vec)
    );

    // {tag, write addr, write data, read addr, expected}
    typedef struct packed {
        logic [7:0]  tag;
        logic [5:0]  wa;
        logic [31:0] wd;
        logic [5:0]  ra;
        logic [31:0] exp;
    } vec_row_t;

    localparam int NROWS = 12;
    localparam vec_row_t ROWS [NROWS] = '{
        '{8'd3, 6'd1,  32'h0000_00FF, 6'd1,  32'h0000_00FF},
        '{8'd3, 6'd2,  32'h0000_0F00, 6'd1,  32'h0000_0FFF},
        '{8'd3, 6'd3,  32'h0000_00F0, 6'd1,  32'h0000_0F0F},
        '{8'd3, 6'd1,  32'hFFFF_FFFF, 6'd1,  32'h0000_FFFF},
        '{8'd3, 6'd3,  32'hFFFF_0000, 6'd1,  32'h0000_FFFF},
        '{8'd3, 6'd3,  32'h0000_FFFF, 6'd1,  32'h0000_0000},
        '{8'd3, 6'd4,  32'h0000_01FF, 6'd4,  32'h0000_00FF},
        '{8'd3, 6'd6,  32'h0000_000F, 6'd4,  32'h0000_00F0},
        '{8'd3, 6'd5,  32'h0000_0001, 6'd4,  32'h0000_00F1},
        '{8'd5, 6'd17, 32'h4746_4544, 6'd17, 32'h4746_4544},
        '{8'd5, 6'd24, 32'h8382_8180, 6'd24, 32'h8382_8180},
        '{8'd11, 6'd0, 32'h0000_0000, 6'd0,  ID}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic pop(input string req, input logic [7:0] exp);
        for (int n = 0; n < 30 && !msg_valid; n++) @(negedge clk);
        check(req, {31'd0, msg_valid}, 32'd1);
        check(req, {24'd0, msg_vec}, {24'd0, exp});
        @(negedge clk);
        check("R9 hold", {23'd0, msg_valid, msg_vec}, {23'd0, 1'b1, exp});
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic idle(input string req);
        for (int n = 0; n < 6; n++) @(negedge clk);
        check(req, {31'd0, msg_valid}, 32'd0);
    endtask

    initial begin
        for (int n = 0; n < 3; n++) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 valid", {31'd0, msg_valid}, 32'd0);
        rd_check("R1 uen", 6'd1, 32'd0);
        rd_check("R1 cen", 6'd4, 32'd0);
        rd_check("R1 upend", 6'd10, 32'd0);
        rd_check("R1 table", 6'd16, 32'd0);
        rd_check("R11 id", 6'd0, ID);

        for (int i = 0; i < NROWS; i++) begin
            wr(ROWS[i].wa, ROWS[i].wd);
            rd_check($sformatf("R%0d row%0d", ROWS[i].tag, i), ROWS[i].ra, ROWS[i].exp);
        end

        // program full tables: user k -> 0x40+k, channel k -> 0x80+k (R5)
        for (int w = 0; w < 4; w++)
            wr(6'(16 + w), {8'(8'h43 + 4*w), 8'(8'h42 + 4*w), 8'(8'h41 + 4*w), 8'(8'h40 + 4*w)});
        for (int w = 0; w < 2; w++)
            wr(6'(24 + w), {8'(8'h83 + 4*w), 8'(8'h82 + 4*w), 8'(8'h81 + 4*w), 8'(8'h80 + 4*w)});
        rd_check("R5 user word3", 6'd19, 32'h4F4E_4D4C);
        rd_check("R5 chan word1", 6'd25, 32'h8786_8584);
        wr(6'd4, 32'd0);

        // masked source, then unmask while high
        user_irq[3] = 1'b1;
        @(negedge clk);
        rd_check("R2 ureq", 6'd8, 32'h0000_0008);
        rd_check("R4 upend masked", 6'd10, 32'd0);
        idle("R7 masked");
        wr(6'd2, 32'h0000_0008);
        rd_check("R4 upend", 6'd10, 32'h0000_0008);
        pop("R7 unmask", 8'h43);
        idle("R6 level held");
        user_irq[3] = 1'b0;
        @(negedge clk); @(negedge clk);
        user_irq[3] = 1'b1;
        pop("R6 re-rise", 8'h43);

        // priority and channel numbering
        user_irq = '0;
        wr(6'd1, 32'h0000_FFFF);
        wr(6'd4, 32'h0000_00FF);
        idle("R6 quiet");
        user_irq[5] = 1'b1; user_irq[2] = 1'b1; c2h_irq[1] = 1'b1; h2c_irq[0] = 1'b1;
        @(negedge clk);
        rd_check("R10 creq", 6'd9, 32'h0000_0021);
        pop("R8 first h2c0", 8'h80);
        pop("R10 c2h1", 8'h85);
        pop("R8 user2", 8'h42);
        pop("R8 user5", 8'h45);
        idle("R6 drained");
        wr(6'd4, 32'h0000_0001);
        rd_check("R4 cpend", 6'd11, 32'h0000_0001);

        // reset in mid-run
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1 valid after reset", {31'd0, msg_valid}, 32'd0);
        rd_check("R1 uen after reset", 6'd1, 32'd0);
        rd_check("R1 cpend after reset", 6'd11, 32'd0);
        idle("R1 silent");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule